// File: doc/BRIEF.md
# Multi-Mode Packed SIMD Multiplier

This unit multiplies two 32-bit source words and returns a 64-bit result. A four-bit mode input selects how the words are cut into lanes. The choices are one full-width product, a half-by-full product, pairs of half-word products (kept apart, summed or differenced), pairs of half-by-full products, and four byte products (kept apart or summed). Two carry-less modes are also offered. One is a finite-field product in GF(2^8) on each byte lane. The other is an unreduced polynomial product of the two whole words.

A new operation may enter on every clock. Four shared 17x17 signed multipliers serve every integer mode. The operand selector feeds them either zero- or sign-extended pieces of the sources, and a final adder stage assembles the selected result. The byte-lane field multiply reduces by a programmable polynomial held in a small register. That register resets to 0x1D, which stands for x^8+x^4+x^3+x^2+1. It is loaded through a write strobe.

Top module: `simd_mul_unit`

## Requirements
- R1: An operation presented with `in_valid` high at clock edge k gives `out_valid` high and its `result` after edge k+2. Operations may arrive on consecutive edges, and `out_valid` is low whenever the matching input was not valid. After reset `out_valid` and `result` are 0.
- R2: Mode 0 gives the 64-bit product of `op_a` and `op_b`, both read as two's complement when `is_signed` is 1 and as unsigned otherwise.
- R3: Mode 1 gives the product of `op_a[15:0]` and the whole of `op_b`. The 48-bit value is extended to 64 bits (sign-extended when `is_signed` is 1).
- R4: Mode 2 puts `op_a[15:0]*op_b[15:0]` in `result[31:0]` and `op_a[31:16]*op_b[31:16]` in `result[63:32]`.
- R5: Mode 3 forms the 48-bit products `op_a[15:0]*op_b` and `op_a[31:16]*op_b`. Bits 47:16 of the first go to `result[31:0]`, and bits 47:16 of the second go to `result[63:32]`.
- R6: Mode 4 multiplies byte i of `op_a` by byte i of `op_b` for i = 0..3. Each 16-bit product is placed at `result[16*i+15:16*i]`.
- R7: Mode 5 returns the sum of the four byte-lane products of mode 4, extended to 64 bits.
- R8: Mode 6 returns low half-word product plus high half-word product. Mode 7 returns low minus high. Both are extended to 64 bits.
- R9: Mode 8 multiplies each byte lane in GF(2^8), reducing by x^8 plus the polynomial register. The lane results fill `result[31:0]` in lane order, `result[63:32]` is 0, and `is_signed` has no effect.
- R10: Mode 9 returns the carry-less (XOR-accumulated) 63-bit product of the two words, and `is_signed` has no effect.
- R11: The polynomial register holds 0x1D after reset. A write with `poly_we` at edge k applies to operations accepted at edge k+1 and later. An operation accepted at edge k still uses the old value.
- R12: Modes 10 to 15 produce a zero result.
- R13: In the integer modes (0 to 7) `is_signed` picks two's complement or unsigned reading of every lane operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| mode | input | 4 | Lane split / operation select |
| is_signed | input | 1 | Two's complement lane operands when 1 |
| op_a | input | 32 | First source word |
| op_b | input | 32 | Second source word |
| poly_we | input | 1 | Load the field polynomial register |
| poly_wdata | input | 8 | New field polynomial (low byte, x^8 implied) |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Operation result |

## Verification
Two cases are hard to reach. The first is a polynomial write that lands on the same edge as a field multiply, where the operation in flight must still use the old value. The second is the set of signed extremes: 0x80 bytes, 0x8000 half-words and 0x80000000 words, where the partial products of the shared multipliers must recombine with the right sign. Directed steps set up the same-edge write and the extreme operands in both signedness settings. Seeded random traffic then mixes every mode, bubbles and mid-run polynomial changes back to back, so that each pipeline stage sees a mode switch on every cycle.

// File: rtl/simd_mul_pkg.sv
// Shared constants and types of the packed multiplier.
// Assumes 32-bit sources split into at most four lanes.
package simd_mul_pkg;
    localparam int SRC_W   = 32;
    localparam int RES_W   = 64;
    localparam int LANES   = 4;
    localparam int HALF_W  = SRC_W / 2;
    localparam int BYTE_W  = SRC_W / LANES;
    localparam int MUL_W   = HALF_W + 1;
    localparam int PROD_W  = 2 * MUL_W;
    localparam int POLY_W  = 8;

    localparam logic [3:0] OP_MUL32     = 4'd0;
    localparam logic [3:0] OP_MUL16X32  = 4'd1;
    localparam logic [3:0] OP_DUAL16    = 4'd2;
    localparam logic [3:0] OP_DUAL16X32 = 4'd3;
    localparam logic [3:0] OP_QUAD8     = 4'd4;
    localparam logic [3:0] OP_QUAD8_SUM = 4'd5;
    localparam logic [3:0] OP_DUAL16_ADD= 4'd6;
    localparam logic [3:0] OP_DUAL16_SUB= 4'd7;
    localparam logic [3:0] OP_GF8       = 4'd8;
    localparam logic [3:0] OP_GF32      = 4'd9;

    typedef struct packed {
        logic [MUL_W-1:0] x;
        logic [MUL_W-1:0] y;
    } mul_pair_t;
endpackage

// File: rtl/simd_opsel.sv
// Operand selector: cuts the two source words into four multiplier
// operand pairs for the selected mode, with sign or zero extension.
// Assumes every integer mode can be built from four 17x17 signed products.
module simd_opsel
    import simd_mul_pkg::*;
(
    input  logic [3:0]                  mode,
    input  logic                        sgn,
    input  logic [SRC_W-1:0]            a,
    input  logic [SRC_W-1:0]            b,
    output mul_pair_t [LANES-1:0]       pairs
);
    // Extend a half-word, optionally with its sign.
    function automatic logic [MUL_W-1:0] ext_h(input logic [HALF_W-1:0] v, input logic s);
        return {s & v[HALF_W-1], v};
    endfunction

    // Extend a byte, optionally with its sign.
    function automatic logic [MUL_W-1:0] ext_b(input logic [BYTE_W-1:0] v, input logic s);
        return {{(MUL_W-BYTE_W){s & v[BYTE_W-1]}}, v};
    endfunction

    logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;
    assign a_lo = a[HALF_W-1:0];
    assign a_hi = a[SRC_W-1:HALF_W];
    assign b_lo = b[HALF_W-1:0];
    assign b_hi = b[SRC_W-1:HALF_W];

    // Route source pieces to the four shared multipliers.
    always_comb begin
        pairs = '0;
        case (mode)
            OP_MUL32: begin
                pairs[0] = '{x: ext_h(a_lo, 1'b0), y: ext_h(b_lo, 1'b0)};
                pairs[1] = '{x: ext_h(a_lo, 1'b0), y: ext_h(b_hi, sgn)};
                pairs[2] = '{x: ext_h(a_hi, sgn),  y: ext_h(b_lo, 1'b0)};
                pairs[3] = '{x: ext_h(a_hi, sgn),  y: ext_h(b_hi, sgn)};
            end
            OP_MUL16X32, OP_DUAL16X32: begin
                pairs[0] = '{x: ext_h(a_lo, sgn), y: ext_h(b_lo, 1'b0)};
                pairs[1] = '{x: ext_h(a_lo, sgn), y: ext_h(b_hi, sgn)};
                pairs[2] = '{x: ext_h(a_hi, sgn), y: ext_h(b_lo, 1'b0)};
                pairs[3] = '{x: ext_h(a_hi, sgn), y: ext_h(b_hi, sgn)};
            end
            OP_DUAL16, OP_DUAL16_ADD, OP_DUAL16_SUB: begin
                pairs[0] = '{x: ext_h(a_lo, sgn), y: ext_h(b_lo, sgn)};
                pairs[3] = '{x: ext_h(a_hi, sgn), y: ext_h(b_hi, sgn)};
            end
            OP_QUAD8, OP_QUAD8_SUM: begin
                for (int i = 0; i < LANES; i++) begin
                    pairs[i] = '{x: ext_b(a[i*BYTE_W +: BYTE_W], sgn),
                                 y: ext_b(b[i*BYTE_W +: BYTE_W], sgn)};
                end
            end
            default: pairs = '0;
        endcase
    end
endmodule

// File: rtl/simd_gf_unit.sv
// Carry-less arithmetic: four GF(2^8) lane products reduced by a
// programmable polynomial, and one unreduced 32x32 polynomial product.
// Assumes the polynomial input carries the low byte with x^8 implied.
module simd_gf_unit
    import simd_mul_pkg::*;
(
    input  logic [SRC_W-1:0]   a,
    input  logic [SRC_W-1:0]   b,
    input  logic [POLY_W-1:0]  poly,
    output logic [SRC_W-1:0]   gf8_res,
    output logic [RES_W-1:0]   gf32_res
);
    // Shift-and-reduce field multiply of one byte lane.
    function automatic logic [BYTE_W-1:0] field_mul(input logic [BYTE_W-1:0] x,
                                                    input logic [BYTE_W-1:0] y,
                                                    input logic [POLY_W-1:0] p);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] sh;
        acc = '0;
        sh  = x;
        for (int i = 0; i < BYTE_W; i++) begin
            if (y[i]) acc = acc ^ sh;
            sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? p : '0);
        end
        return acc;
    endfunction

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // One field multiplier per byte lane.
            assign gf8_res[g*BYTE_W +: BYTE_W] =
                field_mul(a[g*BYTE_W +: BYTE_W], b[g*BYTE_W +: BYTE_W], poly);
        end
    endgenerate

    // XOR-accumulate shifted copies of a for the word-wide product.
    always_comb begin
        gf32_res = '0;
        for (int i = 0; i < SRC_W; i++) begin
            if (b[i]) gf32_res = gf32_res ^ ({{(RES_W-SRC_W){1'b0}}, a} << i);
        end
    end
endmodule

// File: rtl/simd_combine.sv
// Reduction stage: shifts, adds or packs the four registered partial
// products into the 64-bit result, or forwards a carry-less result.
// Assumes each partial product is a 34-bit two's complement value.
module simd_combine
    import simd_mul_pkg::*;
(
    input  logic [3:0]                     mode,
    input  logic [LANES-1:0][PROD_W-1:0]   prod,
    input  logic [SRC_W-1:0]               gf8,
    input  logic [RES_W-1:0]               gf32,
    output logic [RES_W-1:0]               res
);
    logic [LANES-1:0][RES_W-1:0] ext;
    logic [RES_W-1:0] half_lo, half_hi;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_ext
            // Sign-extend each partial product to the result width.
            assign ext[g] = {{(RES_W-PROD_W){prod[g][PROD_W-1]}}, prod[g]};
        end
    endgenerate

    // 48-bit half-by-full products rebuilt from two partials each.
    assign half_lo = (ext[1] << HALF_W) + ext[0];
    assign half_hi = (ext[3] << HALF_W) + ext[2];

    // Select and assemble the result for the mode.
    always_comb begin
        case (mode)
            OP_MUL32:      res = (ext[3] << SRC_W) + ((ext[1] + ext[2]) << HALF_W) + ext[0];
            OP_MUL16X32:   res = half_lo;
            OP_DUAL16X32:  res = {half_hi[47:16], half_lo[47:16]};
            OP_DUAL16:     res = {prod[3][SRC_W-1:0], prod[0][SRC_W-1:0]};
            OP_DUAL16_ADD: res = ext[0] + ext[3];
            OP_DUAL16_SUB: res = ext[0] - ext[3];
            OP_QUAD8:      res = {prod[3][15:0], prod[2][15:0], prod[1][15:0], prod[0][15:0]};
            OP_QUAD8_SUM:  res = ext[0] + ext[1] + ext[2] + ext[3];
            OP_GF8:        res = {{(RES_W-SRC_W){1'b0}}, gf8};
            OP_GF32:       res = gf32;
            default:       res = '0;
        endcase
    end
endmodule

// File: rtl/simd_mul_unit.sv
// Packed SIMD multiplier top. Stage one selects operands, runs the four
// shared multipliers and the carry-less logic; stage two reduces and
// registers the result. Latency two, one operation per clock.
// Assumes poly_we writes are rare configuration events.
module simd_mul_unit
    import simd_mul_pkg::*;
#(
    parameter logic [POLY_W-1:0] GF_POLY_RST = 8'h1D
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [3:0]          mode,
    input  logic                is_signed,
    input  logic [SRC_W-1:0]    op_a,
    input  logic [SRC_W-1:0]    op_b,
    input  logic                poly_we,
    input  logic [POLY_W-1:0]   poly_wdata,
    output logic                out_valid,
    output logic [RES_W-1:0]    result
);
    mul_pair_t [LANES-1:0]          pairs;
    logic [LANES-1:0][PROD_W-1:0]   prod_c;
    logic [LANES-1:0][PROD_W-1:0]   s1_prod;
    logic [SRC_W-1:0]               gf8_c, s1_gf8;
    logic [RES_W-1:0]               gf32_c, s1_gf32;
    logic [RES_W-1:0]               res_c;
    logic [POLY_W-1:0]              poly_q;
    logic                           s1_valid;
    logic [3:0]                     s1_mode;

    simd_opsel u_opsel (
        .mode  (mode),
        .sgn   (is_signed),
        .a     (op_a),
        .b     (op_b),
        .pairs (pairs)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_mul
            // Shared signed 17x17 multiplier, one per lane slot.
            assign prod_c[g] = PROD_W'($signed(pairs[g].x) * $signed(pairs[g].y));
        end
    endgenerate

    simd_gf_unit u_gf (
        .a        (op_a),
        .b        (op_b),
        .poly     (poly_q),
        .gf8_res  (gf8_c),
        .gf32_res (gf32_c)
    );

    // Field polynomial configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)       poly_q <= GF_POLY_RST;
        else if (poly_we) poly_q <= poly_wdata;
    end

    // Stage one: capture partial products and carry-less results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_mode  <= '0;
            s1_prod  <= '0;
            s1_gf8   <= '0;
            s1_gf32  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_mode  <= mode;
            s1_prod  <= prod_c;
            s1_gf8   <= gf8_c;
            s1_gf32  <= gf32_c;
        end
    end

    simd_combine u_comb (
        .mode (s1_mode),
        .prod (s1_prod),
        .gf8  (s1_gf8),
        .gf32 (s1_gf32),
        .res  (res_c)
    );

    // Stage two: register the assembled result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1_valid;
            result    <= res_c;
        end
    end

    // R1: an accepted operation reaches stage one on the next edge.
    assert_stage1_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    // R1: stage one valid becomes the output strobe one edge later.
    assert_out_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    // R1: no output strobe without an operation behind it.
    assert_no_ghost_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);
    // R11: a polynomial write is held from the next edge on.
    assert_poly_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        poly_we |=> (poly_q == $past(poly_wdata)));
    // R9: the byte-lane field mode leaves the upper half clear.
    assert_gf8_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_mode == OP_GF8) |=> (result[63:32] == '0));
    // R12: reserved modes give a zero result.
    assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_mode > OP_GF32) |=> (result == '0));
endmodule

// File: tb/sim_simd_mul_unit.sv
module sim_simd_mul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic        is_signed = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        poly_we = 1'b0;
    logic [7:0]  poly_wdata = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    logic [7:0] cur_poly = 8'h1D;

    bit          h1_v = 0, h2_v = 0;
    logic [63:0] h1_r = '0, h2_r = '0;
    string       h1_t = "R1", h2_t = "R1";

    always #2 clk = ~clk;

    simd_mul_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .is_signed(is_signed), .op_a(op_a), .op_b(op_b),
        .poly_we(poly_we), .poly_wdata(poly_wdata),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] xt(input logic [63:0] v, input int w, input bit s);
        logic [63:0] m;
        m = ~64'd0 << w;
        if (s && v[w-1]) return v | m;
        return v & ~m;
    endfunction

    // Field product: full carry-less product, then fold from the top bit.
    function automatic logic [7:0] gf_ref(input logic [7:0] x, input logic [7:0] y, input logic [7:0] p);
        logic [15:0] t;
        t = '0;
        for (int i = 0; i < 8; i++) if (y[i]) t = t ^ (16'(x) << i);
        for (int k = 14; k >= 8; k--) if (t[k]) t = t ^ ({7'd0, 1'b1, p} << (k - 8));
        return t[7:0];
    endfunction

    function automatic logic [63:0] model(input logic [3:0] m, input bit s,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [7:0] p);
        logic [63:0] pl, ph, r;
        logic [63:0] q [4];
        r = '0;
        for (int i = 0; i < 4; i++)
            q[i] = xt(64'(a[8*i +: 8]), 8, s) * xt(64'(b[8*i +: 8]), 8, s);
        case (m)
            4'd0: r = xt(64'(a), 32, s) * xt(64'(b), 32, s);
            4'd1: r = xt(64'(a[15:0]), 16, s) * xt(64'(b), 32, s);
            4'd3: begin
                pl = xt(64'(a[15:0]), 16, s) * xt(64'(b), 32, s);
                ph = xt(64'(a[31:16]), 16, s) * xt(64'(b), 32, s);
                r = {ph[47:16], pl[47:16]};
            end
            4'd2, 4'd6, 4'd7: begin
                pl = xt(64'(a[15:0]), 16, s) * xt(64'(b[15:0]), 16, s);
                ph = xt(64'(a[31:16]), 16, s) * xt(64'(b[31:16]), 16, s);
                if (m == 4'd2) r = {ph[31:0], pl[31:0]};
                else if (m == 4'd6) r = pl + ph;
                else r = pl - ph;
            end
            4'd4: r = {q[3][15:0], q[2][15:0], q[1][15:0], q[0][15:0]};
            4'd5: r = q[0] + q[1] + q[2] + q[3];
            4'd8: for (int i = 0; i < 4; i++) r[8*i +: 8] = gf_ref(a[8*i +: 8], b[8*i +: 8], p);
            4'd9: for (int i = 0; i < 32; i++) if (b[i]) r = r ^ (64'(a) << i);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd0: return "R2";  4'd1: return "R3";  4'd2: return "R4";
            4'd3: return "R5";  4'd4: return "R6";  4'd5: return "R7";
            4'd6, 4'd7: return "R8";
            4'd8: return "R9";  4'd9: return "R10";
            default: return "R12";
        endcase
    endfunction

    // One cycle: check the output of the op driven two steps back, then drive.
    task automatic step(input bit v, input logic [3:0] m, input bit s,
                        input logic [31:0] a, input logic [31:0] b,
                        input string t = "", input bit we = 0, input logic [7:0] wd = '0);
        @(negedge clk);
        checks++;
        if (out_valid !== h2_v) begin
            errors++;
            $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, h2_v);
        end
        if (h2_v) begin
            checks++;
            if (result !== h2_r) begin
                errors++;
                $display("FAIL %s result actual %h expected %h", h2_t, result, h2_r);
            end
        end
        h2_v = h1_v; h2_r = h1_r; h2_t = h1_t;
        h1_v = v;
        h1_r = model(m, s, a, b, cur_poly);
        h1_t = (t == "") ? tag_of(m) : t;
        in_valid = v; mode = m; is_signed = s; op_a = a; op_b = b;
        poly_we = we; poly_wdata = wd;
        if (we) cur_poly = wd;
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) step(0, 4'd0, 0, '0, '0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        checks++;
        if (out_valid !== 1'b0 || result !== 64'd0) begin
            errors++;
            $display("FAIL R1 reset actual %b/%h expected 0/0", out_valid, result);
        end
        rst_n = 1'b1;

        // R11: first field multiply uses the reset polynomial 0x1D
        step(1, 4'd8, 0, 32'h57_83_02_FF, 32'h83_57_80_FF, "R11");
        // R2, R13: full-width extremes, both signedness settings
        step(1, 4'd0, 1, 32'h8000_0000, 32'h8000_0000);
        step(1, 4'd0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R13");
        step(1, 4'd0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R13");
        step(1, 4'd0, 1, 32'h7FFF_FFFF, 32'h8000_0000);
        // R3, R5
        step(1, 4'd1, 1, 32'h1234_8000, 32'h8000_0001);
        step(1, 4'd1, 0, 32'h1234_FFFF, 32'hFFFF_FFFF);
        step(1, 4'd3, 1, 32'h8000_7FFF, 32'h8000_0000);
        step(1, 4'd3, 0, 32'hFFFF_0001, 32'hDEAD_BEEF);
        // R4, R8
        step(1, 4'd2, 1, 32'h8000_8000, 32'h8000_7FFF);
        step(1, 4'd2, 0, 32'hFFFF_FFFF, 32'hFFFF_0002);
        step(1, 4'd6, 1, 32'h8000_8000, 32'h8000_8000);
        step(1, 4'd7, 1, 32'h0001_8000, 32'h7FFF_8000);
        step(1, 4'd7, 0, 32'h0001_0002, 32'hFFFF_0003);
        // R6, R7, R13 byte extremes
        step(1, 4'd4, 1, 32'h80_7F_FF_80, 32'h80_80_FF_7F);
        step(1, 4'd4, 0, 32'h80_7F_FF_80, 32'h80_80_FF_7F, "R13");
        step(1, 4'd5, 1, 32'h80_80_80_80, 32'h80_80_80_80);
        step(1, 4'd5, 0, 32'hFF_FF_FF_FF, 32'hFF_FF_FF_FF);
        // R9, R10: signedness must not matter
        step(1, 4'd8, 1, 32'h57_83_02_FF, 32'h83_57_80_FF, "R9");
        step(1, 4'd9, 0, 32'hFFFF_FFFF, 32'h8000_0001);
        step(1, 4'd9, 1, 32'hFFFF_FFFF, 32'h8000_0001, "R10");
        // R12: reserved modes
        step(1, 4'd15, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step(1, 4'd10, 0, 32'h1234_5678, 32'h9ABC_DEF0);
        // R11: write on the same edge as an op (old poly), then next op (new)
        step(1, 4'd8, 0, 32'h57_57_57_57, 32'h83_13_02_80, "R11", 1'b1, 8'h1B);
        step(1, 4'd8, 0, 32'h57_57_57_57, 32'h83_13_02_80, "R11");
        // R1: bubbles between ops
        step(0, 4'd0, 0, 32'h5, 32'h7);
        step(1, 4'd0, 0, 32'h5, 32'h7, "R1");
        step(0, 4'd9, 0, 32'h5, 32'h7);
        drain();

        // Random mix, with occasional polynomial changes
        for (int n = 0; n < 1200; n++) begin
            bit          wv;
            logic [31:0] ra, rb;
            wv = ($urandom % 100) < 85;
            ra = $urandom;
            rb = $urandom;
            if ((n % 300) == 150)
                step(wv, 4'($urandom % 16), 1'($urandom), ra, rb, "", 1'b1, 8'($urandom));
            else
                step(wv, 4'($urandom % 16), 1'($urandom), ra, rb);
        end
        drain();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule